// File: doc/BRIEF.md
# Privileged Event Counter Bank

This block holds three 32-bit event counters, each reached through one shared data location. A small selection register names which counter that location currently targets. Each counter has its own event-select field that picks one line of an incoming event-pulse vector. In every cycle where the chosen line is high, the counter advances by one.

Software reaches the bank through a simple request port. A request carries a valid strobe, a write flag, a register index, write data and a privilege flag. The bank answers one cycle later with registered read data and a fault flag. A user-enable bit decides whether unprivileged requests may touch the selection, data and event-select registers. The overflow-interrupt enable mask always stays privileged-only. A blocked request raises the fault flag and changes nothing.

The register indices are: 0 selection (bits [1:0]), 1 counter data (bits [31:0] of the selected counter), 2 event select of the selected counter (bits [2:0]), 3 user enable (bit 0), 4 interrupt enable mask (bit i belongs to counter i). Indices 5 to 7 are unmapped.

Top module: `evt_cnt_bank`

## Requirements
- R1: All counters and event-select fields reset to 0. A counter whose selected event line (event-select value e picks evt_in[e]) is high in a cycle holds the incremented value from the next cycle on. Otherwise it holds its value.
- R2: Index 1 reads or writes the counter named by the selection register (index 0, bits [1:0]). Index 2 does the same for that counter's event-select field.
- R3: A counter holding 0xFFFFFFFF that sees its event wraps to 0.
- R4: If a granted write to a counter and that counter's event land in the same cycle, the counter takes the written value.
- R5: The user-enable register holds one bit at bit 0 and resets to 0. Bits [31:1] read as 0, and writes to them are dropped.
- R6: Any request may read the user-enable register without fault. An unprivileged write to it faults and leaves it unchanged.
- R7: With the enable bit at 0, an unprivileged request to index 0, 1 or 2 faults, returns 0 and has no effect.
- R8: With the enable bit at 1, unprivileged requests to index 0, 1 and 2 complete as privileged ones do.
- R9: The interrupt enable mask (index 4, bits [2:0]) is read and written only by privileged requests. Unprivileged requests to it fault whatever the enable bit holds.
- R10: With a selection value of 3, reads of index 1 and 2 return 0 and writes to them change nothing, without a fault.
- R11: rsp_rdata and rsp_fault are registered and answer the request of the previous cycle. rsp_rdata is 0 for writes, faulting requests, idle cycles and the unmapped indices 5 to 7. The unmapped indices never fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request strobe |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_idx | input | 3 | Register index |
| req_wdata | input | 32 | Write data |
| req_priv | input | 1 | Request is privileged |
| evt_in | input | 8 | Event pulse lines |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| rsp_fault | output | 1 | Access blocked, one cycle after the request |

## Verification
The bench targets several corner cases, each with a visible failure if the design gets it wrong:

- **Enable bit set for user access.** The interrupt mask must still fault. A design that treats every register alike would let the access through.
- **Unprivileged write to the enable bit.** A design that checks only reads would let user code unlock itself.
- **Event and write in the same cycle.** A design that gives the increment priority would read back the written value plus one.
- **Wrap at the top of the range.** A counter that stuck at the maximum would never return to 0.
- **Selection value of 3.** A design that indexed the counter array without a bounds check would return stale or undefined data, or corrupt a real counter.
- **Event-select change.** A design that used the new field in the same cycle would count the wrong line.

// File: rtl/evt_bank_pkg.sv
package evt_bank_pkg;
  localparam int IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    REG_SEL   = 3'd0,
    REG_DATA  = 3'd1,
    REG_EVSEL = 3'd2,
    REG_UEN   = 3'd3,
    REG_IRQEN = 3'd4
  } reg_idx_e;
endpackage

// File: rtl/evt_access_ctl.sv
module evt_access_ctl
  import evt_bank_pkg::*;
(
  input  logic             req_vld,
  input  logic             req_wr,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             req_priv,
  input  logic             uen,
  output logic             grant,
  output logic             fault,
  output logic             wr_sel,
  output logic             wr_data,
  output logic             wr_evsel,
  output logic             wr_uen,
  output logic             wr_irq
);
  logic ok;

  always_comb begin
    unique case (req_idx)
      REG_SEL, REG_DATA, REG_EVSEL: ok = req_priv | uen;
      REG_UEN:                      ok = !req_wr | req_priv;
      REG_IRQEN:                    ok = req_priv;
      default:                      ok = 1'b1;
    endcase
  end

  assign grant    = req_vld & ok;
  assign fault    = req_vld & !ok;
  assign wr_sel   = grant & req_wr & (req_idx == REG_SEL);
  assign wr_data  = grant & req_wr & (req_idx == REG_DATA);
  assign wr_evsel = grant & req_wr & (req_idx == REG_EVSEL);
  assign wr_uen   = grant & req_wr & (req_idx == REG_UEN);
  assign wr_irq   = grant & req_wr & (req_idx == REG_IRQEN);
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CTR_W   = 32,
  parameter int NUM_EVT = 8,
  localparam int ES_W   = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               wr_cnt,
  input  logic               wr_es,
  input  logic [CTR_W-1:0]   wdata,
  output logic [CTR_W-1:0]   cnt,
  output logic [ES_W-1:0]    evsel
);
  logic hit;
  assign hit = evt_in[evsel];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      evsel <= '0;
    end else begin
      if (wr_cnt)   cnt <= wdata;
      else if (hit) cnt <= cnt + 1'b1;
      if (wr_es) evsel <= wdata[ES_W-1:0];
    end
  end

  p_write_wins_r4: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> (cnt == $past(wdata)));
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (!wr_cnt && hit && (cnt == {CTR_W{1'b1}})) |=> (cnt == '0));
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!wr_cnt && !hit) |=> $stable(cnt));
endmodule

// File: rtl/evt_cnt_bank.sv
module evt_cnt_bank
  import evt_bank_pkg::*;
#(
  parameter int NUM_CTR = 3,
  parameter int CTR_W   = 32,
  parameter int NUM_EVT = 8,
  localparam int SEL_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR + 1) : 1,
  localparam int ES_W   = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_vld,
  input  logic               req_wr,
  input  logic [IDX_W-1:0]   req_idx,
  input  logic [CTR_W-1:0]   req_wdata,
  input  logic               req_priv,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic [CTR_W-1:0]   rsp_rdata,
  output logic               rsp_fault
);
  logic [SEL_W-1:0]   sel_q;
  logic               uen_q;
  logic [NUM_CTR-1:0] irq_q;
  logic grant, fault, wr_sel, wr_data, wr_evsel, wr_uen, wr_irq;
  logic sel_ok;
  logic [CTR_W-1:0] cnt_all [NUM_CTR];
  logic [ES_W-1:0]  es_all  [NUM_CTR];
  logic [CTR_W-1:0] cnt_mux, es_mux, rd_mux;

  evt_access_ctl u_acc (
    .req_vld  (req_vld),
    .req_wr   (req_wr),
    .req_idx  (req_idx),
    .req_priv (req_priv),
    .uen      (uen_q),
    .grant    (grant),
    .fault    (fault),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .wr_evsel (wr_evsel),
    .wr_uen   (wr_uen),
    .wr_irq   (wr_irq)
  );

  assign sel_ok = (sel_q < SEL_W'(NUM_CTR));

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic hit_sel;
    assign hit_sel = sel_ok && (sel_q == SEL_W'(i));
    evt_counter #(.CTR_W(CTR_W), .NUM_EVT(NUM_EVT)) u_ctr (
      .clk    (clk),
      .rst    (rst),
      .evt_in (evt_in),
      .wr_cnt (wr_data & hit_sel),
      .wr_es  (wr_evsel & hit_sel),
      .wdata  (req_wdata),
      .cnt    (cnt_all[i]),
      .evsel  (es_all[i])
    );
  end

  always_comb begin
    cnt_mux = '0;
    es_mux  = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (sel_q == SEL_W'(i)) begin
        cnt_mux = cnt_all[i];
        es_mux  = CTR_W'(es_all[i]);
      end
    end
    unique case (req_idx)
      REG_SEL:   rd_mux = CTR_W'(sel_q);
      REG_DATA:  rd_mux = cnt_mux;
      REG_EVSEL: rd_mux = es_mux;
      REG_UEN:   rd_mux = CTR_W'(uen_q);
      REG_IRQEN: rd_mux = CTR_W'(irq_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      uen_q     <= 1'b0;
      irq_q     <= '0;
      rsp_rdata <= '0;
      rsp_fault <= 1'b0;
    end else begin
      if (wr_sel) sel_q <= req_wdata[SEL_W-1:0];
      if (wr_uen) uen_q <= req_wdata[0];
      if (wr_irq) irq_q <= req_wdata[NUM_CTR-1:0];
      rsp_rdata <= (grant && !req_wr) ? rd_mux : '0;
      rsp_fault <= fault;
    end
  end

  p_user_uen_write_r6: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_wr && !req_priv && req_idx == REG_UEN) |=> (rsp_fault && $stable(uen_q)));
  p_user_block_r7: assert property (@(posedge clk) disable iff (rst)
    (req_vld && !req_priv && !uen_q && req_idx <= REG_EVSEL) |=> (rsp_fault && rsp_rdata == '0));
  p_user_open_r8: assert property (@(posedge clk) disable iff (rst)
    (req_vld && !req_priv && uen_q && req_idx <= REG_EVSEL) |=> !rsp_fault);
  p_irq_guard_r9: assert property (@(posedge clk) disable iff (rst)
    (req_vld && !req_priv && req_idx == REG_IRQEN) |=> rsp_fault);
  p_badsel_r10: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_priv && !sel_ok && req_idx == REG_DATA) |=> (!rsp_fault && rsp_rdata == '0));
  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> (!rsp_fault && rsp_rdata == '0));
endmodule

// File: tb/evt_cnt_bank_test.sv
module evt_cnt_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_vld = 1'b0, req_wr = 1'b0, req_priv = 1'b0;
  logic [2:0]  req_idx = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  evt_in = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_fault;

  int checks = 0, failures = 0;
  bit cmp_en = 0;
  string tag = "R11";

  logic [31:0] m_cnt [3];
  int          m_es  [3];
  int          m_sel;
  bit          m_uen;
  logic [2:0]  m_irq;
  logic [31:0] e_rd;
  bit          e_f;

  always #10 clk = ~clk;

  evt_cnt_bank uut (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_wr(req_wr), .req_idx(req_idx),
    .req_wdata(req_wdata), .req_priv(req_priv), .evt_in(evt_in),
    .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault)
  );

  always @(posedge clk) begin
    bit ok;
    logic [31:0] rd;
    if (rst) begin
      for (int i = 0; i < 3; i++) begin m_cnt[i] = 0; m_es[i] = 0; end
      m_sel = 0; m_uen = 0; m_irq = 0; e_rd = 0; e_f = 0;
    end else begin
      ok = 1; rd = 0;
      if (req_vld) begin
        if (req_idx <= 2)      ok = req_priv || m_uen;
        else if (req_idx == 3) ok = !req_wr || req_priv;
        else if (req_idx == 4) ok = req_priv;
        if (ok && !req_wr) begin
          case (req_idx)
            0: rd = m_sel;
            1: rd = (m_sel < 3) ? m_cnt[m_sel] : 0;
            2: rd = (m_sel < 3) ? m_es[m_sel] : 0;
            3: rd = {31'b0, m_uen};
            4: rd = {29'b0, m_irq};
            default: rd = 0;
          endcase
        end
      end
      for (int i = 0; i < 3; i++) begin
        if (req_vld && ok && req_wr && req_idx == 1 && m_sel == i) m_cnt[i] = req_wdata;
        else if (evt_in[m_es[i]]) m_cnt[i] = m_cnt[i] + 1;
      end
      if (req_vld && ok && req_wr) begin
        case (req_idx)
          0: m_sel = req_wdata[1:0];
          2: if (m_sel < 3) m_es[m_sel] = req_wdata[2:0];
          3: m_uen = req_wdata[0];
          4: m_irq = req_wdata[2:0];
          default: ;
        endcase
      end
      e_rd = rd;
      e_f  = !(req_vld ? ok : 1'b1);
    end
  end

  task automatic compare();
    if (!cmp_en) return;
    checks++;
    if (rsp_rdata !== e_rd || rsp_fault !== e_f) begin
      failures++;
      $display("FAIL %s: rdata=%h fault=%b expected rdata=%h fault=%b at %0t",
               tag, rsp_rdata, rsp_fault, e_rd, e_f, $time);
    end
  endtask

  task automatic cyc(input bit v, input bit w, input int idx, input logic [31:0] d,
                     input bit p, input logic [7:0] ev);
    @(negedge clk);
    compare();
    req_vld = v; req_wr = w; req_idx = idx[2:0]; req_wdata = d; req_priv = p; evt_in = ev;
  endtask

  task automatic wr(input int idx, input logic [31:0] d, input bit p);
    cyc(1, 1, idx, d, p, 8'h00);
  endtask
  task automatic rd(input int idx, input bit p);
    cyc(1, 0, idx, 0, p, 8'h00);
  endtask
  task automatic idle(input int n, input logic [7:0] ev);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, ev);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cmp_en = 1;
    tag = "R5"; rd(3, 1); rd(3, 0); rd(0, 1); rd(1, 1); idle(1, 0);
    tag = "R1";
    wr(0, 0, 1); wr(2, 2, 1); wr(0, 1, 1); wr(2, 5, 1); wr(0, 2, 1); wr(2, 0, 1);
    idle(5, 8'h25); idle(3, 8'h04); idle(2, 8'h01);
    tag = "R2";
    for (int s = 0; s < 3; s++) begin wr(0, s, 1); rd(1, 1); rd(2, 1); end
    tag = "R3"; wr(0, 0, 1); wr(1, 32'hFFFF_FFFE, 1); idle(2, 8'h04); rd(1, 1);
    tag = "R4"; cyc(1, 1, 1, 32'h1234_5678, 1, 8'h04); rd(1, 1); idle(1, 0);
    tag = "R7"; wr(0, 2, 0); rd(1, 0); wr(1, 7, 0); wr(2, 3, 0); rd(0, 1); rd(1, 1);
    tag = "R6"; wr(3, 1, 0); rd(3, 0); wr(3, 32'hFFFF_FFFF, 1); rd(3, 0);
    tag = "R8"; wr(0, 1, 0); rd(0, 0); wr(1, 32'hA5A5_0000, 0); rd(1, 0); wr(2, 7, 0); rd(2, 0);
    tag = "R9"; wr(4, 5, 0); rd(4, 0); wr(4, 6, 1); rd(4, 1); rd(4, 0);
    tag = "R10"; wr(0, 3, 1); rd(1, 1); rd(2, 1); wr(1, 99, 1); wr(2, 1, 1);
    for (int s = 0; s < 3; s++) begin wr(0, s, 1); rd(1, 1); rd(2, 1); end
    tag = "R11"; rd(5, 0); wr(6, 1, 0); rd(7, 1); idle(1, 0);
    for (int i = 0; i < 400; i++)
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 7),
          ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom, $urandom_range(0, 1),
          8'($urandom));
    tag = "R6"; wr(3, 0, 1); rd(3, 0);
    tag = "R7"; wr(1, 5, 0); rd(1, 0);
    idle(2, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule